// File: doc/BRIEF.md
# Linked-Descriptor Chained DMA Channel

This block is one DMA channel that walks a chain of transfer descriptors held in ordinary memory. Each descriptor gives a source start address, a destination start address, a byte count and the address of the next descriptor. The channel reads a descriptor over its memory master port, moves the data it describes one unit at a time (a read from the source, then a write to the destination), and then follows the next-descriptor address. A next-descriptor address of zero ends the chain. At the end the channel pulses an active-low terminal-count output for one clock, raises an interrupt request and disables itself.

Software sets the channel up through a small write-only register port. It writes the even address of the first descriptor, writes a nonzero count and then writes the control word with the enable bit set. When the channel is enabled, the first-descriptor address is copied into the chain pointer. In burst mode one request runs the whole chain. In cycle-steal mode each request buys one unit transfer, and the descriptor fetch that comes before the unit when a new descriptor is due.

Top module: `chain_dma`

## Requirements
- R1: After reset `tc_n` is 1, `irq` and `busy` are 0, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: Register address 0 holds the first-descriptor address. A write of an odd value there is ignored and the previous value is kept. Address 1 is the count register. Address 2 is control: bit0 enables, bit1 selects cycle-steal (0 selects burst), and bit2 selects 16-bit units (0 selects byte units). An enable is ignored while the count register is zero. Writes to addresses 0 and 1, and the mode bits of a control write, are ignored while `busy` is 1.
- R3: A descriptor fetch makes eight 16-bit reads at pointer, pointer+2, up to pointer+14. Word k carries the low word (k even) or the upper 8 bits in bits 7:0 (k odd) of, in this order, the source (k=0,1), the destination (k=2,3), the count (k=4,5) and the next pointer (k=6,7). The first fetch begins at the address written to register 0.
- R4: A unit transfer is a read at the source address and then a write at the destination address. In 16-bit mode the whole word is copied and `mem_word` is 1. In byte mode `mem_word` is 0, and the byte travels on bits 15:8 for an odd address and on bits 7:0 for an even one.
- R5: After each unit both addresses advance by the unit size (1 or 2), and the count drops by the unit size, stopping at 0. A 16-bit chain with count c therefore moves 2*ceil(c/2) bytes.
- R6: When the count reaches 0 and the next pointer is nonzero, the channel stays enabled and fetches the descriptor at that pointer.
- R7: When the count reaches 0 and the next pointer is zero, `tc_n` goes low for exactly one clock. In that same clock `irq` is 1 and `busy` is 0, and no further bus cycle follows.
- R8: In burst mode a single request pulse carries the whole chain to its end.
- R9: In cycle-steal mode each request pulse performs at most one descriptor fetch and one unit transfer, and the channel then waits for the next request.
- R10: A fetched descriptor with a count of 0 moves no data, and the channel goes straight on to its next pointer, or ends the chain if that pointer is zero.
- R11: While `mem_ready` is 0, an asserted strobe and its address are held unchanged.
- R12: A write to the control register clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 first descriptor, 1 count, 2 control) |
| cfg_wdata | input | 24 | Register write data |
| dma_req | input | 1 | Transfer request pulse |
| mem_addr | output | 24 | Byte address of the current bus access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | 1 for a 16-bit access, 0 for a byte access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the word that holds mem_addr |
| mem_ready | input | 1 | Access completes on a clock edge where this is 1 |
| tc_n | output | 1 | Active-low one-clock end-of-chain pulse |
| irq | output | 1 | Interrupt request, set at end of chain |
| busy | output | 1 | Channel enable bit |

## Verification
The hardest situation to reach from the ports is the channel parked halfway through a chain in cycle-steal mode, with a descriptor already fetched but only part of its count moved. A close second is a zero-count descriptor followed through while the memory inserts random wait states. The bench sweeps chain length, unit size, request mode and the ready pattern. In cycle-steal runs it issues one request at a time, waits for the write that request caused, and checks that the bus then stays silent. The three-descriptor chains run with random wait states and carry an empty descriptor in the middle. Expected memory contents, bus-cycle counts and fetch addresses are all derived from the descriptor values.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned HI_W       = ADDR_W - DATA_W;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned BYTE_W     = DATA_W / 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_FETCH, S_XRD, S_XWR, S_EVAL
  } seq_state_e;

  function automatic addr_t unit_size(logic wide);
    return wide ? addr_t'(2) : addr_t'(1);
  endfunction

  function automatic addr_t count_after(addr_t cnt, logic wide);
    addr_t step = unit_size(wide);
    return (cnt > step) ? cnt - step : '0;
  endfunction

  function automatic addr_t desc_addr(addr_t base, logic [IDX_W-1:0] idx);
    return base + addr_t'({idx, 1'b0});
  endfunction

  function automatic data_t lane_pick(data_t rd, logic a0, logic wide);
    if (wide) return rd;
    if (a0) return data_t'(rd[DATA_W-1:BYTE_W]);
    return data_t'(rd[BYTE_W-1:0]);
  endfunction

  function automatic data_t lane_place(data_t v, logic a0, logic wide);
    if (wide) return v;
    if (a0) return {v[BYTE_W-1:0], {BYTE_W{1'b0}}};
    return data_t'(v[BYTE_W-1:0]);
  endfunction
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  addr_t            cfg_wdata,
  input  logic             dma_req,
  input  logic             fetch_we,
  input  logic [IDX_W-1:0] fetch_idx,
  input  data_t            fetch_data,
  input  logic             unit_done,
  input  logic             chain_end,
  input  logic             steal_done,
  output addr_t            src_q,
  output addr_t            dst_q,
  output addr_t            cnt_q,
  output addr_t            ptr_q,
  output logic             en_q,
  output logic             steal_q,
  output logic             wide_q,
  output logic             req_q,
  output logic             irq_q,
  output logic             tc_n_q
);
  data_t nxt_lo_q;
  logic [IDX_W-2:0] field;
  logic hi_half;

  assign field   = fetch_idx[IDX_W-1:1];
  assign hi_half = fetch_idx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; ptr_q <= '0; nxt_lo_q <= '0;
      en_q <= 1'b0; steal_q <= 1'b0; wide_q <= 1'b0; req_q <= 1'b0;
      irq_q <= 1'b0; tc_n_q <= 1'b1;
    end else begin
      tc_n_q <= !chain_end;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: if (!en_q && !cfg_wdata[0]) src_q <= cfg_wdata;
          2'd1: if (!en_q) cnt_q <= cfg_wdata;
          2'd2: begin
            irq_q <= 1'b0;
            if (!en_q) begin
              steal_q <= cfg_wdata[1];
              wide_q  <= cfg_wdata[2];
              if (cfg_wdata[0] && cnt_q != '0) begin
                en_q  <= 1'b1;
                ptr_q <= src_q;
              end
            end
          end
          default: ;
        endcase
      end
      if (fetch_we) begin
        case (field)
          2'd0: if (hi_half) src_q[ADDR_W-1:DATA_W] <= fetch_data[HI_W-1:0];
                else         src_q[DATA_W-1:0]      <= fetch_data;
          2'd1: if (hi_half) dst_q[ADDR_W-1:DATA_W] <= fetch_data[HI_W-1:0];
                else         dst_q[DATA_W-1:0]      <= fetch_data;
          2'd2: if (hi_half) cnt_q[ADDR_W-1:DATA_W] <= fetch_data[HI_W-1:0];
                else         cnt_q[DATA_W-1:0]      <= fetch_data;
          default: if (hi_half) ptr_q <= {fetch_data[HI_W-1:0], nxt_lo_q[DATA_W-1:1], 1'b0};
                   else         nxt_lo_q <= fetch_data;
        endcase
      end
      if (unit_done) begin
        src_q <= src_q + unit_size(wide_q);
        dst_q <= dst_q + unit_size(wide_q);
        cnt_q <= count_after(cnt_q, wide_q);
      end
      if (steal_done) req_q <= 1'b0;
      if (dma_req && en_q) req_q <= 1'b1;
      if (chain_end) begin
        en_q  <= 1'b0;
        req_q <= 1'b0;
        irq_q <= 1'b1;
      end
    end
  end

  // R7: terminal count is a single-clock pulse
  a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_n_q |=> tc_n_q);
  // R7: terminal count coincides with interrupt and disable
  a_r7_tc_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_n_q |-> (irq_q && !en_q && !req_q));
  // R5: count never grows across a unit
  a_r5_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (cnt_q < $past(cnt_q) || cnt_q == '0));
  // R6: a fetch never drops the enable
  a_r6_fetch_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_we |=> en_q);
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req,
  input  logic             steal,
  input  logic             cnt_zero,
  input  logic             ptr_zero,
  input  logic             mem_ready,
  output seq_state_e       state_q,
  output logic [IDX_W-1:0] widx_q,
  output logic             fetch_we,
  output logic             unit_rd_done,
  output logic             unit_done,
  output logic             chain_end,
  output logic             steal_done
);
  seq_state_e nxt;
  logic need_fetch_q, from_fetch_q;
  logic last_word, go_on;

  assign last_word    = (widx_q == IDX_W'(DESC_WORDS - 1));
  assign fetch_we     = (state_q == S_FETCH) && mem_ready;
  assign unit_rd_done = (state_q == S_XRD) && mem_ready;
  assign unit_done    = (state_q == S_XWR) && mem_ready;
  assign chain_end    = (state_q == S_EVAL) && cnt_zero && ptr_zero;
  assign steal_done   = (state_q == S_EVAL) && steal && !from_fetch_q && !chain_end;
  assign go_on        = from_fetch_q || !steal;

  always_comb begin
    nxt = state_q;
    case (state_q)
      S_IDLE:  if (en) nxt = S_WAIT;
      S_WAIT:  if (req) nxt = need_fetch_q ? S_FETCH : S_XRD;
      S_FETCH: if (mem_ready && last_word) nxt = S_EVAL;
      S_XRD:   if (mem_ready) nxt = S_XWR;
      S_XWR:   if (mem_ready) nxt = S_EVAL;
      S_EVAL: begin
        if (chain_end)     nxt = S_IDLE;
        else if (cnt_zero) nxt = go_on ? S_FETCH : S_WAIT;
        else               nxt = go_on ? S_XRD : S_WAIT;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      widx_q       <= '0;
      need_fetch_q <= 1'b0;
      from_fetch_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (fetch_we) widx_q <= last_word ? '0 : widx_q + IDX_W'(1);
      if (state_q == S_IDLE && en) need_fetch_q <= 1'b1;
      if (state_q == S_WAIT && req) need_fetch_q <= 1'b0;
      if (state_q == S_EVAL && cnt_zero && !chain_end && !go_on) need_fetch_q <= 1'b1;
      if (fetch_we && last_word) from_fetch_q <= 1'b1;
      if (unit_done) from_fetch_q <= 1'b0;
    end
  end

  // R9: a cycle-steal unit returns to waiting (or ends)
  a_r9_one_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EVAL && steal && !from_fetch_q) |=> (state_q == S_WAIT || state_q == S_IDLE));
  // R8: burst mode never parks mid-chain
  a_r8_burst_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EVAL && !steal && !chain_end) |=> (state_q != S_WAIT));
  // R10: an empty descriptor leads straight to the next fetch
  a_r10_skip_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EVAL && from_fetch_q && cnt_zero && !ptr_zero) |=> (state_q == S_FETCH));
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import cdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              dma_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_word,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              tc_n,
  output logic              irq,
  output logic              busy
);
  addr_t src, dst, cnt, ptr;
  logic en, steal, wide, req;
  seq_state_e state;
  logic [IDX_W-1:0] widx;
  logic fetch_we, unit_rd_done, unit_done, chain_end, steal_done;
  data_t hold_q;

  cdma_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .dma_req,
    .fetch_we, .fetch_idx(widx), .fetch_data(mem_rdata),
    .unit_done, .chain_end, .steal_done,
    .src_q(src), .dst_q(dst), .cnt_q(cnt), .ptr_q(ptr),
    .en_q(en), .steal_q(steal), .wide_q(wide), .req_q(req),
    .irq_q(irq), .tc_n_q(tc_n)
  );

  cdma_seq u_seq (
    .clk, .rst_n, .en, .req, .steal,
    .cnt_zero(cnt == '0), .ptr_zero(ptr == '0), .mem_ready,
    .state_q(state), .widx_q(widx),
    .fetch_we, .unit_rd_done, .unit_done, .chain_end, .steal_done
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (unit_rd_done) hold_q <= lane_pick(mem_rdata, src[0], wide);
  end

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_word  = 1'b1;
    mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_addr = desc_addr(ptr, widx);
        mem_rd   = 1'b1;
      end
      S_XRD: begin
        mem_addr = src;
        mem_rd   = 1'b1;
        mem_word = wide;
      end
      S_XWR: begin
        mem_addr  = dst;
        mem_wr    = 1'b1;
        mem_word  = wide;
        mem_wdata = lane_place(hold_q, dst[0], wide);
      end
      default: ;
    endcase
  end

  assign busy = en;

  // R4: never read and write at once
  a_r4_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R11: a stalled read holds strobe and address
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  // R11: a stalled write holds strobe, address and data
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  // R7: a disabled channel is silent on the bus
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
  // R3: descriptor reads are word aligned
  a_r3_fetch_even: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |-> (mem_rd && mem_word && !mem_addr[0]));
endmodule

// File: tb/chain_dma_tb.sv
module chain_dma_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic dma_req = 1'b0;
  logic [23:0] mem_addr;
  logic mem_rd, mem_wr, mem_word, mem_ready, tc_n, irq, busy;
  logic [15:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  chain_dma u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .dma_req,
    .mem_addr, .mem_rd, .mem_wr, .mem_word, .mem_wdata, .mem_rdata,
    .mem_ready, .tc_n, .irq, .busy
  );

  logic [7:0] mem [0:4095];
  logic [7:0] expm [0:4095];
  logic [11:0] ma;
  logic [7:0] lfsr = 8'h5A;
  logic rdy_mode = 1'b0;

  assign ma = mem_addr[11:0];
  assign mem_rdata = {mem[{ma[11:1], 1'b1}], mem[{ma[11:1], 1'b0}]};
  assign mem_ready = rdy_mode ? (lfsr[0] | lfsr[2]) : 1'b1;

  int n_rd = 0, n_wr = 0, tc_low = 0, tc_bad = 0;
  logic [23:0] rd_log [0:63];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n) begin
      if (mem_rd && mem_ready) begin
        rd_log[n_rd % 64] <= mem_addr;
        n_rd <= n_rd + 1;
      end
      if (mem_wr && mem_ready) begin
        n_wr <= n_wr + 1;
        if (mem_word) begin
          mem[{ma[11:1], 1'b0}] <= mem_wdata[7:0];
          mem[{ma[11:1], 1'b1}] <= mem_wdata[15:8];
        end else if (ma[0]) mem[ma] <= mem_wdata[15:8];
        else mem[ma] <= mem_wdata[7:0];
      end
      if (!tc_n) begin
        tc_low <= tc_low + 1;
        if (!irq || busy) tc_bad <= tc_bad + 1;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    dma_req = 1'b1;
    @(negedge clk);
    dma_req = 1'b0;
  endtask

  task automatic put_word(input int a, input logic [15:0] w);
    mem[a] <= w[7:0];
    mem[a + 1] <= w[15:8];
  endtask

  task automatic run_chain(input int nd, input bit wide, input bit steal,
                           input bit rdy, input int seed);
    int base [0:3];
    int srca [0:3];
    int dsta [0:3];
    int cnta [0:3];
    int units = 0, units0 = 0, r0, w0, t0, b0, reqs, mism;
    string tg;
    tg = $sformatf("nd=%0d w=%0d s=%0d r=%0d", nd, wide, steal, rdy);
    rdy_mode = rdy;
    for (int a = 'h400; a < 'h900; a++) begin
      logic [7:0] v;
      v = (a < 'h800) ? 8'((a * 13 + seed * 7) & 'hff) : 8'h00;
      mem[a] <= v;
      expm[a] = v;
    end
    for (int i = 0; i < nd; i++) begin
      base[i] = 'h100 + 'h10 * (nd - 1 - i);
      srca[i] = 'h400 + 'h40 * i + (wide ? 0 : (i & 1));
      dsta[i] = 'h800 + 'h40 * i + (wide ? 0 : ((i + 1) & 1));
      cnta[i] = (nd == 3 && rdy && i == 1) ? 0 : 1 + ((seed + 5 * i) % 9);
    end
    for (int i = 0; i < nd; i++) begin
      int nxt, u, nb;
      nxt = (i == nd - 1) ? 0 : base[i + 1];
      put_word(base[i] + 0,  16'(srca[i]));
      put_word(base[i] + 2,  16'(srca[i] >> 16));
      put_word(base[i] + 4,  16'(dsta[i]));
      put_word(base[i] + 6,  16'(dsta[i] >> 16));
      put_word(base[i] + 8,  16'(cnta[i]));
      put_word(base[i] + 10, 16'(cnta[i] >> 16));
      put_word(base[i] + 12, 16'(nxt));
      put_word(base[i] + 14, 16'(nxt >> 16));
      u = wide ? (cnta[i] + 1) / 2 : cnta[i];
      nb = wide ? 2 * u : u;
      if (i == 0) units0 = u;
      units += u;
      for (int j = 0; j < nb; j++) expm[dsta[i] + j] = expm[srca[i] + j];
    end
    cfg_write(2'd0, 24'(base[0]));
    cfg_write(2'd0, 24'(base[0] + 1));   // odd: must be ignored (R2)
    cfg_write(2'd1, 24'd1);
    r0 = n_rd; w0 = n_wr; t0 = tc_low; b0 = tc_bad;
    cfg_write(2'd2, {21'd0, wide, steal, 1'b1});
    chk({"R2 busy after enable ", tg}, 32'(busy), 1);
    if (!steal) begin
      pulse_req();
      for (int k = 0; k < 8000 && !irq; k++) @(negedge clk);
    end else begin
      reqs = 0;
      while (!irq && reqs < 100) begin
        int wbefore;
        wbefore = n_wr;
        pulse_req();
        reqs++;
        for (int k = 0; k < 3000 && n_wr == wbefore && !irq; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        if (reqs == 1) begin
          chk({"R9 reads after first request ", tg}, 32'(n_rd - r0), 32'(9));
          chk({"R9 writes after first request ", tg}, 32'(n_wr - w0), 1);
          if (!irq) begin
            repeat (10) @(negedge clk);
            chk({"R9 silent until next request ", tg}, 32'(n_rd - r0), 32'(9));
          end
        end
      end
      chk({"R9 requests equal units ", tg}, 32'(reqs), 32'(units));
    end
    repeat (20) @(negedge clk);
    chk({"R3 R2 first fetch address ", tg}, 32'(rd_log[r0 % 64]), 32'(base[0]));
    chk({"R3 second fetch word address ", tg}, 32'(rd_log[(r0 + 1) % 64]), 32'(base[0] + 2));
    if (nd > 1)
      chk({"R6 next descriptor address ", tg}, 32'(rd_log[(r0 + 8 + units0) % 64]), 32'(base[1]));
    chk({"R3 R10 total reads ", tg}, 32'(n_rd - r0), 32'(8 * nd + units));
    chk({"R5 total writes ", tg}, 32'(n_wr - w0), 32'(units));
    chk({"R7 tc low cycles ", tg}, 32'(tc_low - t0), 1);
    chk({"R7 tc with irq and disabled ", tg}, 32'(tc_bad - b0), 0);
    chk({"R7 irq set ", tg}, 32'(irq), 1);
    chk({"R7 busy cleared ", tg}, 32'(busy), 0);
    mism = 0;
    for (int a = 'h800; a < 'h900; a++) if (mem[a] !== expm[a]) mism++;
    chk({"R4 R5 R11 destination contents ", tg}, 32'(mism), 0);
    cfg_write(2'd2, 24'd0);
    chk({"R12 irq cleared ", tg}, 32'(irq), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] <= 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 tc_n in reset", 32'(tc_n), 1);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 no strobes after reset", 32'({mem_rd, mem_wr}), 0);
    chk("R1 tc_n after reset", 32'(tc_n), 1);
    begin
      int r0;
      r0 = n_rd;
      cfg_write(2'd1, 24'd0);
      cfg_write(2'd2, 24'd1);
      pulse_req();
      repeat (10) @(negedge clk);
      chk("R2 enable ignored with zero count", 32'(busy), 0);
      chk("R2 no bus activity with zero count", 32'(n_rd - r0), 0);
    end
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++)
          for (int n = 1; n <= 3; n++)
            run_chain(n, bit'(w), bit'(s), bit'(r), w * 11 + s * 5 + r * 3 + n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule